// File: doc/BRIEF.md
# Decimal Adjust and ASCII Adjust Unit

This unit carries out the legacy binary-coded-decimal correction steps that follow an ordinary binary add, subtract, multiply or precede a divide. It works on an 8-bit accumulator byte and an 8-bit companion (high) byte, takes the incoming carry and auxiliary-carry flags, and for the multiply and divide helpers a radix value (normally ten). It returns the corrected bytes together with carry, auxiliary-carry, zero, sign and parity flags.

A 3-bit code picks the operation. All results are computed in one combinational stage and captured in an output register, so a new operation can be issued on every clock. Codes that name no operation copy the inputs to the outputs. A radix of zero for the multiply helper is outside the intended use; the unit then returns a defined but meaningless result.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While reset is low at a rising clock edge, every output is driven to zero at that edge.
- R2: Outputs are registered. The result for the inputs present at a rising edge appears after that edge and stays until the next edge.
- R3: Code 1 (packed add adjust): when the low nibble of the byte is above 9 or auxiliary carry is in, 6 is added to the byte and auxiliary carry out is 1. Otherwise auxiliary carry out is 0.
- R4: Code 1: when the byte before any correction is above 0x99 or carry is in, 0x60 is also added and carry out is 1. Otherwise carry out is 0.
- R5: Code 2 (packed subtract adjust): under the nibble condition of R3, 6 is subtracted, auxiliary carry out is 1, and carry out is 1 if the byte was below 6 or carry was in. When the byte before correction is above 0x99 or carry is in, 0x60 is also subtracted and carry out is 1. Any flag not set in this way is 0.
- R6: Code 3 (unpacked add adjust): when the low nibble is above 9 or auxiliary carry is in, the low result is (low+6) with bits 7:4 cleared, the high byte gains 1 and gains 1 more if the low byte was above 0xF9, and carry and auxiliary carry out are both 1.
- R7: Code 4 (unpacked subtract adjust): under the condition of R6, the low result is (low-6) with bits 7:4 cleared, the high byte loses 1 and loses 1 more if the low byte was below 6, and carry and auxiliary carry out are both 1.
- R8: Codes 3 and 4 when the condition of R6 is false: carry and auxiliary carry out are 0, bits 7:4 of the low byte are cleared, and the high byte is unchanged.
- R9: Code 5 (split after multiply): the high result is the low byte divided by the radix, the low result is the remainder, and carry and auxiliary carry out are 0.
- R10: Code 6 (merge before divide): the low result is high times radix plus low, kept to 8 bits. The high result is 0, and carry and auxiliary carry out are 0.
- R11: For every code, zero out is 1 when the low result is 0, sign out equals bit 7 of the low result, and parity out is 1 when the low result has an even number of set bits.
- R12: Codes 0 and 7 copy both bytes, carry and auxiliary carry to the outputs unchanged.
- R13: Codes 1 and 2 return the high byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code |
| lo_i | input | 8 | Accumulator (low) byte |
| hi_i | input | 8 | Companion (high) byte |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| radix_i | input | 8 | Radix for codes 5 and 6 |
| lo_o | output | 8 | Corrected low byte |
| hi_o | output | 8 | Corrected high byte |
| cf_o | output | 1 | Carry flag out |
| af_o | output | 1 | Auxiliary-carry flag out |
| zf_o | output | 1 | Zero flag out |
| sf_o | output | 1 | Sign flag out |
| pf_o | output | 1 | Even-parity flag out |

## Verification
The packed adjusts are tried with a nibble above 9 alone, carry or auxiliary carry alone, both paths together, and the exact value 0x99. Together these separate the pre-correction comparison from a post-correction one. For subtraction, a byte below 6 shows whether carry comes from the borrow term or from the 0x99 term. The unpacked adjusts are run with low bytes of 0xF9, 0xFA, 0x02 and 0x06, which show whether the extra high-byte step is taken, and with a carry in and no nibble condition, which shows whether carry is cleared. The multiply and divide helpers use radix 10 and 16 and a product that wraps to zero, and the pass codes use bytes that set the sign and zero flags.

// File: rtl/bcd_adj_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, operation codes and BCD constants for the
// decimal/ASCII adjust unit. Assumes byte-wide operands.
package bcd_adj_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    localparam logic [NIB_W-1:0]  NIB_MAX_DIGIT = 4'd9;
    localparam logic [BYTE_W-1:0] LO_STEP       = 8'h06;
    localparam logic [BYTE_W-1:0] HI_STEP       = 8'h60;
    localparam logic [BYTE_W-1:0] PACKED_MAX    = 8'h99;
    localparam logic [BYTE_W-1:0] UNP_ADD_WRAP  = 8'hF9;

    typedef enum logic [2:0] {
        OP_PASS      = 3'd0,
        OP_DEC_ADD   = 3'd1,
        OP_DEC_SUB   = 3'd2,
        OP_UNP_ADD   = 3'd3,
        OP_UNP_SUB   = 3'd4,
        OP_MUL_SPLIT = 3'd5,
        OP_DIV_MERGE = 3'd6,
        OP_PASS_ALT  = 3'd7
    } adj_op_e;
endpackage

// File: rtl/packed_adjust.sv
`timescale 1ns/1ps
// packed_adjust: decimal correction of a packed BCD byte after a binary add
// (sub_mode=0) or subtract (sub_mode=1). Purely combinational.
// Assumes carry/aux inputs describe the preceding binary operation.
module packed_adjust
    import bcd_adj_pkg::*;
(
    input  logic              sub_mode,
    input  logic [BYTE_W-1:0] acc,
    input  logic              cf_in,
    input  logic              af_in,
    output logic [BYTE_W-1:0] acc_out,
    output logic              cf_out,
    output logic              af_out
);
    logic lo_fix;
    logic hi_fix;

    // Both conditions are taken from the byte before any correction.
    always_comb begin
        lo_fix = (acc[NIB_W-1:0] > NIB_MAX_DIGIT) || af_in;
        hi_fix = (acc > PACKED_MAX) || cf_in;
    end

    // Apply the low-digit step, then the high-digit step.
    always_comb begin
        acc_out = acc;
        cf_out  = 1'b0;
        af_out  = 1'b0;
        if (lo_fix) begin
            af_out = 1'b1;
            if (sub_mode) begin
                if ((acc < LO_STEP) || cf_in) begin
                    cf_out = 1'b1;
                end
                acc_out = acc - LO_STEP;
            end else begin
                acc_out = acc + LO_STEP;
            end
        end
        if (hi_fix) begin
            cf_out  = 1'b1;
            acc_out = sub_mode ? (acc_out - HI_STEP) : (acc_out + HI_STEP);
        end
    end
endmodule

// File: rtl/unpacked_adjust.sv
`timescale 1ns/1ps
// unpacked_adjust: correction of an unpacked (one digit per byte) result
// after an add (sub_mode=0) or subtract (sub_mode=1), propagating into the
// high byte. Purely combinational.
module unpacked_adjust
    import bcd_adj_pkg::*;
(
    input  logic              sub_mode,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic              af_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out,
    output logic              cf_out,
    output logic              af_out
);
    logic              fix;
    logic              extra;
    logic [BYTE_W-1:0] lo_step;

    // Decide whether to correct and whether the high byte takes a second step.
    always_comb begin
        fix     = (lo[NIB_W-1:0] > NIB_MAX_DIGIT) || af_in;
        extra   = sub_mode ? (lo < LO_STEP) : (lo > UNP_ADD_WRAP);
        lo_step = sub_mode ? (lo - LO_STEP) : (lo + LO_STEP);
    end

    // Form the corrected bytes and the two carries.
    always_comb begin
        if (fix) begin
            lo_out = {{(BYTE_W-NIB_W){1'b0}}, lo_step[NIB_W-1:0]};
            if (sub_mode) begin
                hi_out = hi - 8'd1 - {{(BYTE_W-1){1'b0}}, extra};
            end else begin
                hi_out = hi + 8'd1 + {{(BYTE_W-1){1'b0}}, extra};
            end
            cf_out = 1'b1;
            af_out = 1'b1;
        end else begin
            lo_out = {{(BYTE_W-NIB_W){1'b0}}, lo[NIB_W-1:0]};
            hi_out = hi;
            cf_out = 1'b0;
            af_out = 1'b0;
        end
    end
endmodule

// File: rtl/radix_adjust.sv
`timescale 1ns/1ps
// radix_adjust: split a byte into quotient/remainder by a radix (after a
// multiply, merge_mode=0) or fold two digits into one binary byte (before a
// divide, merge_mode=1). Assumes radix is non-zero when splitting; a zero
// radix returns all-ones quotient and the byte as remainder.
module radix_adjust
    import bcd_adj_pkg::*;
(
    input  logic              merge_mode,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] radix,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out
);
    logic              radix_zero;
    logic [BYTE_W-1:0] quo;
    logic [BYTE_W-1:0] rem;
    logic [BYTE_W-1:0] merged;

    // Quotient, remainder and merged value, each kept to one byte.
    always_comb begin
        radix_zero = (radix == '0);
        quo        = radix_zero ? '1 : (lo / radix);
        rem        = radix_zero ? lo : (lo % radix);
        merged     = (hi * radix) + lo;
    end

    // Select the split or merge result.
    always_comb begin
        if (merge_mode) begin
            lo_out = merged;
            hi_out = '0;
        end else begin
            lo_out = rem;
            hi_out = quo;
        end
    end
endmodule

// File: rtl/result_flags.sv
`timescale 1ns/1ps
// result_flags: zero, sign and even-parity of a result byte. Combinational.
module result_flags
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] value,
    output logic              zf,
    output logic              sf,
    output logic              pf
);
    // Derive the three status bits from the byte.
    always_comb begin
        zf = (value == '0);
        sf = value[BYTE_W-1];
        pf = ~^value;
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
`timescale 1ns/1ps
// bcd_adjust_unit: selects one of the decimal/ASCII adjust operations by a
// 3-bit code, computes bytes and flags in one combinational stage and
// registers them. Synchronous active-low reset clears all outputs.
// Assumes a non-zero radix for the split operation.
module bcd_adjust_unit
    import bcd_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              cf_i,
    input  logic              af_i,
    input  logic [BYTE_W-1:0] radix_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              cf_o,
    output logic              af_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              pf_o
);
    adj_op_e           op;
    logic [BYTE_W-1:0] pk_lo;
    logic              pk_cf, pk_af;
    logic [BYTE_W-1:0] up_lo, up_hi;
    logic              up_cf, up_af;
    logic [BYTE_W-1:0] rx_lo, rx_hi;
    logic [BYTE_W-1:0] nxt_lo, nxt_hi;
    logic              nxt_cf, nxt_af;
    logic              nxt_zf, nxt_sf, nxt_pf;

    assign op = adj_op_e'(op_i);

    packed_adjust u_packed (
        .sub_mode (op == OP_DEC_SUB),
        .acc      (lo_i),
        .cf_in    (cf_i),
        .af_in    (af_i),
        .acc_out  (pk_lo),
        .cf_out   (pk_cf),
        .af_out   (pk_af)
    );

    unpacked_adjust u_unpacked (
        .sub_mode (op == OP_UNP_SUB),
        .lo       (lo_i),
        .hi       (hi_i),
        .af_in    (af_i),
        .lo_out   (up_lo),
        .hi_out   (up_hi),
        .cf_out   (up_cf),
        .af_out   (up_af)
    );

    radix_adjust u_radix (
        .merge_mode (op == OP_DIV_MERGE),
        .lo         (lo_i),
        .hi         (hi_i),
        .radix      (radix_i),
        .lo_out     (rx_lo),
        .hi_out     (rx_hi)
    );

    // Route the selected operation's result to the register inputs.
    always_comb begin
        nxt_lo = lo_i;
        nxt_hi = hi_i;
        nxt_cf = cf_i;
        nxt_af = af_i;
        case (op)
            OP_DEC_ADD, OP_DEC_SUB: begin
                nxt_lo = pk_lo;
                nxt_cf = pk_cf;
                nxt_af = pk_af;
            end
            OP_UNP_ADD, OP_UNP_SUB: begin
                nxt_lo = up_lo;
                nxt_hi = up_hi;
                nxt_cf = up_cf;
                nxt_af = up_af;
            end
            OP_MUL_SPLIT, OP_DIV_MERGE: begin
                nxt_lo = rx_lo;
                nxt_hi = rx_hi;
                nxt_cf = 1'b0;
                nxt_af = 1'b0;
            end
            default: begin
            end
        endcase
    end

    result_flags u_flags (
        .value (nxt_lo),
        .zf    (nxt_zf),
        .sf    (nxt_sf),
        .pf    (nxt_pf)
    );

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o <= '0;
            hi_o <= '0;
            cf_o <= 1'b0;
            af_o <= 1'b0;
            zf_o <= 1'b0;
            sf_o <= 1'b0;
            pf_o <= 1'b0;
        end else begin
            lo_o <= nxt_lo;
            hi_o <= nxt_hi;
            cf_o <= nxt_cf;
            af_o <= nxt_af;
            zf_o <= nxt_zf;
            sf_o <= nxt_sf;
            pf_o <= nxt_pf;
        end
    end

    a_r12_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i == 3'd7) |=>
            (lo_o == $past(lo_i) && hi_o == $past(hi_i) &&
             cf_o == $past(cf_i) && af_o == $past(af_i)));

    a_r13_packed_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 || op_i == 3'd2) |=> (hi_o == $past(hi_i)));

    a_r6_unpacked_fix_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd3 || op_i == 3'd4) && (lo_i[3:0] > 4'd9 || af_i)) |=>
            (cf_o && af_o && lo_o[7:4] == 4'd0));

    a_r8_unpacked_no_fix: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd3 || op_i == 3'd4) && lo_i[3:0] <= 4'd9 && !af_i) |=>
            (!cf_o && !af_o && lo_o[7:4] == 4'd0 && hi_o == $past(hi_i)));

    a_r9_remainder_below_radix: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5 && radix_i != 8'd0) |=>
            (lo_o < $past(radix_i) && !cf_o && !af_o));

    a_r10_merge_clears_high: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6) |=> (hi_o == 8'd0 && !cf_o && !af_o));

    a_r4_packed_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> (cf_o == ($past(lo_i) > 8'h99 || $past(cf_i))));
endmodule

// File: tb/bcd_adjust_unit_tb.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed reset/latency tests.
module bcd_adjust_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] lo_i = 8'h00, hi_i = 8'h00, radix_i = 8'h00;
    logic       cf_i = 1'b0, af_i = 1'b0;
    logic [7:0] lo_o, hi_o;
    logic       cf_o, af_o, zf_o, sf_o, pf_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bcd_adjust_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .lo_i(lo_i), .hi_i(hi_i),
        .cf_i(cf_i), .af_i(af_i), .radix_i(radix_i),
        .lo_o(lo_o), .hi_o(hi_o), .cf_o(cf_o), .af_o(af_o),
        .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o)
    );

    // {op, lo, hi, cf, af, radix,  lo', hi', cf', af', zf', sf', pf'}
    localparam int NV = 27;
    localparam logic [49:0] VEC [NV] = '{
        {3'd1,8'h0F,8'h00,1'b0,1'b0,8'h00, 8'h15,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0}, // R3
        {3'd1,8'h9A,8'h12,1'b0,1'b0,8'h00, 8'h00,8'h12,1'b1,1'b1,1'b1,1'b0,1'b1}, // R4 R13
        {3'd1,8'h12,8'h00,1'b1,1'b1,8'h00, 8'h78,8'h00,1'b1,1'b1,1'b0,1'b0,1'b1}, // R4
        {3'd1,8'h45,8'h00,1'b0,1'b0,8'h00, 8'h45,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3
        {3'd1,8'h99,8'h00,1'b0,1'b0,8'h00, 8'h99,8'h00,1'b0,1'b0,1'b0,1'b1,1'b1}, // R4
        {3'd2,8'h0F,8'h00,1'b0,1'b0,8'h00, 8'h09,8'h00,1'b0,1'b1,1'b0,1'b0,1'b1}, // R5
        {3'd2,8'h03,8'h00,1'b0,1'b1,8'h00, 8'hFD,8'h00,1'b1,1'b1,1'b0,1'b1,1'b0}, // R5
        {3'd2,8'hA5,8'h00,1'b0,1'b0,8'h00, 8'h45,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0}, // R5
        {3'd2,8'h20,8'h00,1'b1,1'b0,8'h00, 8'hC0,8'h00,1'b1,1'b0,1'b0,1'b1,1'b1}, // R5
        {3'd2,8'h00,8'h33,1'b1,1'b1,8'h00, 8'h9A,8'h33,1'b1,1'b1,1'b0,1'b1,1'b1}, // R5 R13
        {3'd3,8'h0C,8'h01,1'b0,1'b0,8'h00, 8'h02,8'h02,1'b1,1'b1,1'b0,1'b0,1'b0}, // R6
        {3'd3,8'hFA,8'h05,1'b0,1'b0,8'h00, 8'h00,8'h07,1'b1,1'b1,1'b1,1'b0,1'b1}, // R6
        {3'd3,8'hF9,8'h00,1'b0,1'b1,8'h00, 8'h0F,8'h01,1'b1,1'b1,1'b0,1'b0,1'b1}, // R6
        {3'd3,8'h33,8'h04,1'b0,1'b1,8'h00, 8'h09,8'h05,1'b1,1'b1,1'b0,1'b0,1'b1}, // R6
        {3'd3,8'h37,8'h02,1'b1,1'b0,8'h00, 8'h07,8'h02,1'b0,1'b0,1'b0,1'b0,1'b0}, // R8
        {3'd4,8'h0F,8'h03,1'b0,1'b0,8'h00, 8'h09,8'h02,1'b1,1'b1,1'b0,1'b0,1'b1}, // R7
        {3'd4,8'h02,8'h00,1'b0,1'b1,8'h00, 8'h0C,8'hFE,1'b1,1'b1,1'b0,1'b0,1'b1}, // R7
        {3'd4,8'h06,8'h10,1'b0,1'b1,8'h00, 8'h00,8'h0F,1'b1,1'b1,1'b1,1'b0,1'b1}, // R7
        {3'd4,8'h58,8'h09,1'b0,1'b0,8'h00, 8'h08,8'h09,1'b0,1'b0,1'b0,1'b0,1'b0}, // R8
        {3'd5,8'h3F,8'h44,1'b0,1'b0,8'h0A, 8'h03,8'h06,1'b0,1'b0,1'b0,1'b0,1'b1}, // R9
        {3'd5,8'hFF,8'h00,1'b0,1'b0,8'h10, 8'h0F,8'h0F,1'b0,1'b0,1'b0,1'b0,1'b1}, // R9
        {3'd5,8'h07,8'h00,1'b1,1'b1,8'h0A, 8'h07,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R9
        {3'd6,8'h05,8'h07,1'b0,1'b0,8'h0A, 8'h4B,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R10
        {3'd6,8'h09,8'h0F,1'b0,1'b0,8'h10, 8'hF9,8'h00,1'b0,1'b0,1'b0,1'b1,1'b1}, // R10 R11
        {3'd6,8'h10,8'h18,1'b1,1'b1,8'h0A, 8'h00,8'h00,1'b0,1'b0,1'b1,1'b0,1'b1}, // R10 R11
        {3'd0,8'h81,8'h22,1'b1,1'b0,8'h00, 8'h81,8'h22,1'b1,1'b0,1'b0,1'b1,1'b1}, // R12
        {3'd7,8'h00,8'hFF,1'b0,1'b1,8'h00, 8'h00,8'hFF,1'b0,1'b1,1'b1,1'b0,1'b1}  // R12 R11
    };
    localparam int TAG [NV] = '{3,4,4,3,4,5,5,5,5,5,6,6,6,6,8,7,7,7,8,9,9,9,10,10,10,12,12};

    function automatic logic [20:0] outs();
        return {lo_o, hi_o, cf_o, af_o, zf_o, sf_o, pf_o};
    endfunction

    task automatic check(input int req, input logic [20:0] got, input logic [20:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [28:0] stim);
        {op_i, lo_i, hi_i, cf_i, af_i, radix_i} = stim;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset with busy inputs clears every output
        drive({3'd1, 8'h9A, 8'h55, 1'b1, 1'b1, 8'h0A});
        repeat (3) @(negedge clk);
        check(1, outs(), 21'd0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample at the next one
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][49:21]);
            @(negedge clk);
            check(TAG[i], outs(), VEC[i][20:0]);
        end

        // R2: result must not appear before the capturing edge
        drive({3'd0, 8'h11, 8'h00, 1'b0, 1'b0, 8'h00});
        @(negedge clk);
        check(2, {13'd0, lo_o}, {13'd0, 8'h11});
        drive({3'd0, 8'h5A, 8'h00, 1'b0, 1'b0, 8'h00});
        #4;
        check(2, {13'd0, lo_o}, {13'd0, 8'h11});
        @(negedge clk);
        check(2, {13'd0, lo_o}, {13'd0, 8'h5A});

        // R1: reset in mid-run overrides a carrying operation
        rst_n = 1'b0;
        drive({3'd1, 8'h9A, 8'h12, 1'b1, 1'b1, 8'h00});
        @(negedge clk);
        check(1, outs(), 21'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R13 after reset release: 0x9A with carry in gives 0x00, high kept
        check(4, outs(), {8'h00, 8'h12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1});

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule